// File: doc/BRIEF.md
# Inter-Processor Interrupt Cause Unit

This block holds a 16-bit pending-cause word for each core of a cluster and turns those causes into three interrupt request lines per core. Any core can post a cause: it writes a core bitmask to one of sixteen "post" addresses, one address per cause bit. The bit is then set in every core named by the mask. A core retires causes by writing a clear mask to that core's cause address. Reading the same address returns the pending causes.

The sixteen cause bits are folded into four groups of 1, 3, 4 and 8 bits. An 8-bit steering register has a 2-bit field per group that sends the group to request line 0, 1 or 2. Field value 3 discards the group. Groups that share a line are ORed. Every core has its own register bus port. All ports act in the same cycle, and the block defines how their writes merge. Read data is combinational from the port address. The request lines are registered.

Top module: `ipi_cause_unit`

## Requirements
- R1: Reset clears every cause word, the steering register and all request lines to 0.
- R2: A write to address 0x140+k (k = 0..15) sets cause bit k in each core c whose bit c of the write data is 1. Bits of the mask at or above NUM_CORES are ignored, and other cause bits are left as they were.
- R3: A write to address 0x100+c (c < NUM_CORES) clears the bits of core c's cause word that are 1 in the write data. A read of that address returns the cause word.
- R4: The steering register sits at address 0x190. A write loads it from write data bits [7:0], and a read returns it zero-extended to 16 bits. Group g is steered by bits [2g+1:2g].
- R5: Group 0 is cause bit 0, group 1 is bits 1..3, group 2 is bits 4..7 and group 3 is bits 8..15. A group is active when any of its bits is 1.
- R6: An active group drives the line (bit 0..2 of the core's 3-bit output slice) selected by its field. Groups on the same line are ORed, and a field of 3 drops the group.
- R7: A core's request lines change on the clock edge after the edge that updates its cause word or the steering register.
- R8: If a post and a clear reach the same cause bit in the same cycle, the bit ends up set.
- R9: In the same cycle, posts from several ports are ORed and clears are ORed. When several ports write the steering register, the lowest-numbered port wins.
- R10: Writes to any other address, including cause addresses of cores at or above NUM_CORES, change nothing. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | NUM_CORES | Write strobe, one per core port |
| bus_addr | input | NUM_CORES*ADDR_W | Register address per port (port p at bits [p*ADDR_W +: ADDR_W]) |
| bus_wdata | input | NUM_CORES*16 | Write data per port |
| bus_rdata | output | NUM_CORES*16 | Combinational read data per port |
| irq_lines | output | NUM_CORES*3 | Registered request lines, core c at bits [c*3 +: 3] |

## Verification
The bench targets these corner cases:
- A post and a clear that land on one bit from two ports in the same cycle. A clear-wins design would leave the bit at 0.
- Two ports writing the steering register together. A wrong priority would show the higher port's value on readback.
- A field of 3. Mapping it onto a fourth or wrapped line would raise a request that should stay low.
- Post masks with bits above the core count, and cause addresses of cores that do not exist. A decoder that aliases these would alter a real core's word.
- The cycle in which the lines move. An output taken straight from the cause word would move one cycle early.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int CAUSE_W = 16;
    localparam int GROUPS  = 4;
    localparam int LINES   = 3;
    localparam int FIELD_W = 2;
    localparam int STEER_W = GROUPS * FIELD_W;

    localparam int unsigned CAUSE_BASE = 'h100;
    localparam int unsigned POST_BASE  = 'h140;
    localparam int unsigned STEER_ADDR = 'h190;

    // Fold a cause word into its four group activity flags.
    function automatic logic [GROUPS-1:0] fold_groups(input logic [CAUSE_W-1:0] c);
        fold_groups = {|c[15:8], |c[7:4], |c[3:1], c[0]};
    endfunction

    // Steer active groups onto lines; a field equal to LINES is discarded.
    function automatic logic [LINES-1:0] steer(input logic [GROUPS-1:0]  g,
                                               input logic [STEER_W-1:0] s);
        logic [LINES:0] acc;
        acc = '0;
        for (int i = 0; i < GROUPS; i++) begin
            if (g[i]) acc[s[i*FIELD_W +: FIELD_W]] = 1'b1;
        end
        return acc[LINES-1:0];
    endfunction

endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10
) (
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CAUSE_W-1:0]             wdata,
    input  logic [NUM_CORES*CAUSE_W-1:0]   cause_flat,
    input  logic [STEER_W-1:0]             steer_q,
    output logic [NUM_CORES*CAUSE_W-1:0]   post_flat,
    output logic [NUM_CORES*CAUSE_W-1:0]   clr_flat,
    output logic                           steer_wr,
    output logic [STEER_W-1:0]             steer_val,
    output logic [CAUSE_W-1:0]             rdata
);

    localparam int POST_CNT = CAUSE_W;

    logic                       post_hit;
    logic [$clog2(POST_CNT)-1:0] post_idx;
    logic                       steer_hit;

    assign post_hit  = (addr >= ADDR_W'(POST_BASE)) &&
                       (addr <  ADDR_W'(POST_BASE + POST_CNT));
    assign post_idx  = addr[$clog2(POST_CNT)-1:0];
    assign steer_hit = (addr == ADDR_W'(STEER_ADDR));

    assign steer_wr  = wr_en && steer_hit;
    assign steer_val = wdata[STEER_W-1:0];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic own_hit;
        assign own_hit = (addr == ADDR_W'(CAUSE_BASE + c));
        assign post_flat[c*CAUSE_W +: CAUSE_W] =
            (wr_en && post_hit && wdata[c]) ? (CAUSE_W'(1) << post_idx) : '0;
        assign clr_flat[c*CAUSE_W +: CAUSE_W] =
            (wr_en && own_hit) ? wdata : '0;
    end

    always_comb begin
        rdata = '0;
        if (steer_hit) rdata = CAUSE_W'(steer_q);
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == ADDR_W'(CAUSE_BASE + c)) rdata = cause_flat[c*CAUSE_W +: CAUSE_W];
        end
    end

endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_PORTS = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PORTS*NUM_CORES*CAUSE_W-1:0] post_all,
    input  logic [NUM_PORTS*NUM_CORES*CAUSE_W-1:0] clr_all,
    input  logic [NUM_PORTS-1:0]                   steer_wr,
    input  logic [NUM_PORTS*STEER_W-1:0]           steer_val,
    output logic [NUM_CORES*CAUSE_W-1:0]           cause_flat,
    output logic [STEER_W-1:0]                     steer_q
);

    localparam int SLICE = NUM_CORES * CAUSE_W;

    logic [SLICE-1:0]   post_any;
    logic [SLICE-1:0]   clr_any;
    logic [STEER_W-1:0] steer_nxt;

    always_comb begin
        post_any = '0;
        clr_any  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            post_any |= post_all[p*SLICE +: SLICE];
            clr_any  |= clr_all[p*SLICE +: SLICE];
        end
    end

    // Walk from the highest port down so the lowest writer has the last word.
    always_comb begin
        steer_nxt = steer_q;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (steer_wr[p]) steer_nxt = steer_val[p*STEER_W +: STEER_W];
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_flat[c*CAUSE_W +: CAUSE_W] <= '0;
            end else begin
                cause_flat[c*CAUSE_W +: CAUSE_W] <=
                    (cause_flat[c*CAUSE_W +: CAUSE_W] & ~clr_any[c*CAUSE_W +: CAUSE_W])
                    | post_any[c*CAUSE_W +: CAUSE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) steer_q <= '0;
        else        steer_q <= steer_nxt;
    end

endmodule

// File: rtl/ipi_line_map.sv
module ipi_line_map
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES*CAUSE_W-1:0] cause_flat,
    input  logic [STEER_W-1:0]           steer_q,
    output logic [NUM_CORES*LINES-1:0]   irq_q
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_map
        logic [GROUPS-1:0] grp;
        assign grp = fold_groups(cause_flat[c*CAUSE_W +: CAUSE_W]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q[c*LINES +: LINES] <= '0;
            else        irq_q[c*LINES +: LINES] <= steer(grp, steer_q);
        end
    end

endmodule

// File: rtl/ipi_cause_unit.sv
module ipi_cause_unit
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES-1:0]         bus_we,
    input  logic [NUM_CORES*ADDR_W-1:0]  bus_addr,
    input  logic [NUM_CORES*16-1:0]      bus_wdata,
    output logic [NUM_CORES*16-1:0]      bus_rdata,
    output logic [NUM_CORES*3-1:0]       irq_lines
);

    localparam int NUM_PORTS = NUM_CORES;
    localparam int SLICE     = NUM_CORES * CAUSE_W;

    logic [NUM_PORTS*SLICE-1:0]   post_all;
    logic [NUM_PORTS*SLICE-1:0]   clr_all;
    logic [NUM_PORTS-1:0]         steer_wr;
    logic [NUM_PORTS*STEER_W-1:0] steer_val;
    logic [SLICE-1:0]             cause_flat;
    logic [STEER_W-1:0]           part_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ipi_port_decode #(
            .NUM_CORES (NUM_CORES),
            .ADDR_W    (ADDR_W)
        ) u_dec (
            .wr_en      (bus_we[p]),
            .addr       (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata      (bus_wdata[p*CAUSE_W +: CAUSE_W]),
            .cause_flat (cause_flat),
            .steer_q    (part_q),
            .post_flat  (post_all[p*SLICE +: SLICE]),
            .clr_flat   (clr_all[p*SLICE +: SLICE]),
            .steer_wr   (steer_wr[p]),
            .steer_val  (steer_val[p*STEER_W +: STEER_W]),
            .rdata      (bus_rdata[p*CAUSE_W +: CAUSE_W])
        );
    end

    ipi_cause_bank #(
        .NUM_CORES (NUM_CORES),
        .NUM_PORTS (NUM_PORTS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_all   (post_all),
        .clr_all    (clr_all),
        .steer_wr   (steer_wr),
        .steer_val  (steer_val),
        .cause_flat (cause_flat),
        .steer_q    (part_q)
    );

    ipi_line_map #(
        .NUM_CORES (NUM_CORES)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_flat (cause_flat),
        .steer_q    (part_q),
        .irq_q      (irq_lines)
    );

endmodule

// File: rtl/ipi_cause_checker.sv
module ipi_cause_checker
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CORES-1:0]         bus_we,
    input logic [NUM_CORES*ADDR_W-1:0]  bus_addr,
    input logic                         post_mask0,
    input logic [NUM_CORES*3-1:0]       irq_lines,
    input logic [NUM_CORES*CAUSE_W-1:0] cause_flat,
    input logic [STEER_W-1:0]           part_q
);

    logic any_mapped;
    logic post0;

    always_comb begin
        any_mapped = 1'b0;
        for (int p = 0; p < NUM_CORES; p++) begin
            if (bus_we[p]) begin
                if (bus_addr[p*ADDR_W +: ADDR_W] >= ADDR_W'(CAUSE_BASE) &&
                    bus_addr[p*ADDR_W +: ADDR_W] <  ADDR_W'(CAUSE_BASE + NUM_CORES))
                    any_mapped = 1'b1;
                if (bus_addr[p*ADDR_W +: ADDR_W] >= ADDR_W'(POST_BASE) &&
                    bus_addr[p*ADDR_W +: ADDR_W] <  ADDR_W'(POST_BASE + CAUSE_W))
                    any_mapped = 1'b1;
                if (bus_addr[p*ADDR_W +: ADDR_W] == ADDR_W'(STEER_ADDR))
                    any_mapped = 1'b1;
            end
        end
    end

    assign post0 = bus_we[0] && post_mask0 &&
                   bus_addr[ADDR_W-1:0] >= ADDR_W'(POST_BASE) &&
                   bus_addr[ADDR_W-1:0] <  ADDR_W'(POST_BASE + CAUSE_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (irq_lines == '0 && cause_flat == '0 && part_q == '0); // R1
        end
    end

    AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        post0 |=> cause_flat[$past(bus_addr[3:0])]); // R8

    AST_LINES_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|bus_we) && $past(!(|bus_we))) |=> $stable(irq_lines)); // R7

    AST_DROPPED_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(part_q) == {STEER_W{1'b1}}) |-> (irq_lines == '0)); // R6

    AST_UNMAPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_mapped |=> ($stable(cause_flat) && $stable(part_q))); // R10

endmodule

bind ipi_cause_unit ipi_cause_checker #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .post_mask0 (bus_wdata[0]),
    .irq_lines  (irq_lines),
    .cause_flat (cause_flat),
    .part_q     (part_q)
);

// File: tb/test_ipi_cause_unit.sv
`timescale 1ns/1ps
module test_ipi_cause_unit;

    localparam int N  = 4;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]     bus_we;
    logic [N*AW-1:0]  bus_addr;
    logic [N*16-1:0]  bus_wdata;
    logic [N*16-1:0]  bus_rdata;
    logic [N*3-1:0]   irq_lines;

    logic        b_we    [N];
    logic [AW-1:0] b_addr [N];
    logic [15:0] b_wdata [N];

    always_comb begin
        for (int p = 0; p < N; p++) begin
            bus_we[p]               = b_we[p];
            bus_addr[p*AW +: AW]    = b_addr[p];
            bus_wdata[p*16 +: 16]   = b_wdata[p];
        end
    end

    ipi_cause_unit #(.NUM_CORES(N), .ADDR_W(AW)) i_ipi_cause_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines)
    );

    // Reference state
    logic [15:0] m_cause [N];
    logic [7:0]  m_part;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_lines(input logic [15:0] c, input logic [7:0] s);
        logic [3:0] g;
        logic [2:0] l;
        g[0] = c[0];
        g[1] = c[1] | c[2] | c[3];
        g[2] = c[4] | c[5] | c[6] | c[7];
        g[3] = c[8] | c[9] | c[10] | c[11] | c[12] | c[13] | c[14] | c[15];
        l = 3'b000;
        for (int i = 0; i < 4; i++) begin
            int f;
            f = (s >> (2 * i)) & 3;
            if (g[i] && f < 3) l[f] = 1'b1;
        end
        return l;
    endfunction

    function automatic logic [N*3-1:0] ref_all();
        logic [N*3-1:0] r;
        for (int c = 0; c < N; c++) r[c*3 +: 3] = ref_lines(m_cause[c], m_part);
        return r;
    endfunction

    task automatic model_apply();
        logic [15:0] setm [N];
        logic [15:0] clrm [N];
        bit part_taken;
        logic [7:0] part_new;
        part_taken = 0;
        part_new = m_part;
        for (int c = 0; c < N; c++) begin
            setm[c] = 16'h0;
            clrm[c] = 16'h0;
        end
        for (int p = 0; p < N; p++) begin
            if (b_we[p]) begin
                int a;
                a = int'(b_addr[p]);
                if (a >= 'h140 && a < 'h150) begin
                    for (int c = 0; c < N; c++)
                        if (b_wdata[p][c]) setm[c][a - 'h140] = 1'b1;
                end
                if (a >= 'h100 && a < 'h100 + N) clrm[a - 'h100] |= b_wdata[p];
                if (a == 'h190 && !part_taken) begin
                    part_new = b_wdata[p][7:0];
                    part_taken = 1;
                end
            end
        end
        for (int c = 0; c < N; c++) m_cause[c] = (m_cause[c] & ~clrm[c]) | setm[c];
        m_part = part_new;
    endtask

    task automatic idle();
        for (int p = 0; p < N; p++) begin
            b_we[p] = 1'b0;
            b_addr[p] = '0;
            b_wdata[p] = '0;
        end
    endtask

    task automatic wr(input int p, input int a, input logic [15:0] d);
        b_we[p] = 1'b1;
        b_addr[p] = AW'(a);
        b_wdata[p] = d;
    endtask

    // One clock; request lines checked against the state held before the edge (R7).
    task automatic tick();
        logic [N*3-1:0] exp;
        exp = ref_all();
        @(posedge clk);
        model_apply();
        #1;
        check(irq_lines == exp, "R7", irq_lines, exp);
    endtask

    task automatic rd(input int p, input int a, output logic [15:0] d);
        idle();
        @(negedge clk);
        b_addr[p] = AW'(a);
        #1;
        d = bus_rdata[p*16 +: 16];
    endtask

    task automatic readback_all(input int p, input string req);
        logic [15:0] d;
        for (int c = 0; c < N; c++) begin
            rd(p, 'h100 + c, d);
            check(d == m_cause[c], req, d, m_cause[c]);
        end
        rd(p, 'h190, d);
        check(d == {8'h00, m_part}, req, d, {8'h00, m_part});
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'h5EED_0042));
        idle();
        for (int c = 0; c < N; c++) m_cause[c] = '0;
        m_part = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(irq_lines == '0, "R1", irq_lines, 0);
        readback_all(0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        tick();

        // R2: port 2 posts cause bit 0 to core 1
        wr(2, 'h140, 16'h0002);
        tick();
        idle();
        check(irq_lines[3 +: 3] == 3'b000, "R7", irq_lines[3 +: 3], 0);
        tick();
        check(irq_lines[3 +: 3] == 3'b001, "R5", irq_lines[3 +: 3], 3'b001);
        rd(0, 'h101, d);
        check(d == 16'h0001, "R2", d, 16'h0001);

        // R2: mask bits above the core count are ignored
        wr(0, 'h145, 16'hFFF0);
        tick(); idle(); tick();
        readback_all(3, "R2");

        // R4: steering register; groups 0..3 to lines 0,1,2,dropped
        wr(1, 'h190, 16'hABE4);
        tick(); idle(); tick();
        rd(2, 'h190, d);
        check(d == 16'h00E4, "R4", d, 16'h00E4);

        // R6: group 3 on field 3 raises nothing
        wr(3, 'h14F, 16'h0001);
        tick(); idle(); tick();
        check(irq_lines[0 +: 3] == 3'b000, "R6", irq_lines[0 +: 3], 0);
        // R5: bit 4 is group 2 -> line 2
        wr(3, 'h144, 16'h0001);
        tick(); idle(); tick();
        check(irq_lines[0 +: 3] == 3'b100, "R5", irq_lines[0 +: 3], 3'b100);

        // R6: all groups to line 0 merge by OR
        wr(0, 'h190, 16'h0000);
        tick(); idle(); tick();
        check(irq_lines[0 +: 3] == 3'b001, "R6", irq_lines[0 +: 3], 3'b001);

        // R3: clear core 0 from port 3
        wr(3, 'h100, 16'h8010);
        tick(); idle(); tick();
        rd(1, 'h100, d);
        check(d == 16'h0000, "R3", d, 0);
        check(irq_lines[0 +: 3] == 3'b000, "R3", irq_lines[0 +: 3], 0);

        // R8: post and clear on the same bit in one cycle
        wr(0, 'h143, 16'h0004);
        tick();
        wr(0, 'h147, 16'h0004);
        tick(); idle(); tick();
        wr(0, 'h102, 16'hFFFF);
        wr(1, 'h147, 16'h0004);
        tick(); idle(); tick();
        rd(2, 'h102, d);
        check(d == 16'h0080, "R8", d, 16'h0080);

        // R9: steering writes from two ports, lowest port wins
        wr(3, 'h190, 16'h0055);
        wr(1, 'h190, 16'h00AA);
        tick(); idle(); tick();
        rd(0, 'h190, d);
        check(d == 16'h00AA, "R9", d, 16'h00AA);
        // R9: posts from two ports merge
        wr(0, 'h141, 16'h0008);
        wr(2, 'h148, 16'h0008);
        tick(); idle(); tick();
        rd(3, 'h103, d);
        check(d == 16'h0102, "R9", d, 16'h0102);

        // R10: unmapped addresses and absent cores
        wr(0, 'h1A0, 16'hFFFF);
        wr(1, 'h104, 16'hFFFF);
        wr(2, 'h150, 16'hFFFF);
        wr(3, 'h0FF, 16'hFFFF);
        tick(); idle(); tick();
        readback_all(1, "R10");
        rd(0, 'h104, d);
        check(d == 16'h0000, "R10", d, 0);
        rd(0, 'h1A0, d);
        check(d == 16'h0000, "R10", d, 0);

        // Random traffic on all ports against the reference
        for (int it = 0; it < 1500; it++) begin
            idle();
            for (int p = 0; p < N; p++) begin
                if ($urandom % 2 == 0) begin
                    int a;
                    case ($urandom % 5)
                        0, 4: a = 'h140 + int'($urandom % 16);
                        1:    a = 'h100 + int'($urandom % 6);
                        2:    a = 'h190;
                        default: a = int'($urandom % 1024);
                    endcase
                    wr(p, a, 16'($urandom));
                end
            end
            tick();
            if (it % 60 == 59) begin
                idle();
                tick();
                readback_all(int'($urandom % N), "R9");
            end
        end
        idle();
        tick();
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule